// File: doc/BRIEF.md
# Addressed Serial Port Expander

This block is a slave on a four-wire serial link: an active-low select, a serial clock, a data input and a tri-stateable data output. It is clocked by the system clock. All link inputs pass through two-flop synchronisers, and serial clock edges are found by comparing synchronised samples. Each transaction is a 16-bit frame, sent most significant bit first. The upper byte carries an address and a 3-bit command, and the lower byte carries data. Each input bit is the majority of three consecutive synchronised samples of the data line, taken at the detected rising serial clock.

Once the address part of the frame has arrived, the block compares it with strap inputs. On a match it starts driving reply bits after each falling serial clock. On a mismatch the data output stays released. When select rises, the block executes the command, but only if the frame held exactly 16 rising serial clocks. One command loads an internal output register and a separate command places that register on the 8-bit port. A reply can carry either the port levels captured at frame start or the register contents. A mode input selects between normal framing (4-bit address, acknowledge bit) and echo framing (3-bit address, received bits returned).

Top module: `ioexp_slave`

## Requirements
- R1: After reset, ser_oe, port_oe, port_out and flag are all 0.
- R2: In normal mode the frame, sent MSB first, is: bit 15 don't-care, bits 14..11 address (compared to strap[3:0]), bits 10..8 command, bits 7..0 data. Command 3'b001 loads the data byte into the output register and leaves port_out and port_oe unchanged.
- R3: Command 3'b010 copies the output register to port_out and sets all eight port_oe bits.
- R4: Slot n is the bit the host samples at the n-th rising serial clock. On a match, slots 9..16 carry a byte MSB first. The byte is the register for command 3'b100, and otherwise the port_in levels captured when select fell (command 3'b011 is the port read).
- R5: If the address does not match, ser_oe stays 0 for the whole frame and the command has no effect.
- R6: ser_oe is 0 during slots 1..5 and is 1 from slot 6 on a match. It returns to 0 once select rises.
- R7: A frame with 15 or 17 rising serial clocks executes nothing. The register, port_out, port_oe and flag keep their values.
- R8: In normal mode a matching frame replies 0 in slots 6 and 7, and an acknowledge of 1 in slot 8.
- R9: In echo mode bits 15..14 are don't-care, bits 13..11 are compared to strap[2:0] only, and strap[3] is ignored. Slots 6, 7 and 8 return the received address bit A0 and the first two command bits; the last command bit is not returned.
- R10: A data-input glitch lasting one system clock and coinciding with a rising serial clock does not change the received bit.
- R11: Command 3'b101 sets flag and command 3'b110 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Frame select, low during a frame |
| ser_clk | input | 1 | Serial clock from the host |
| ser_in | input | 1 | Serial data from the host |
| echo_mode | input | 1 | 1 selects echo framing, 0 normal framing |
| strap | input | 4 | Address strap inputs |
| port_in | input | 8 | Port pin levels |
| ser_out | output | 1 | Serial reply data |
| ser_oe | output | 1 | Drive enable for ser_out |
| port_out | output | 8 | Port output levels |
| port_oe | output | 8 | Per-pin port drive enables |
| flag | output | 1 | Status flag |

## Verification
A miscounted serial clock either suppresses a valid command or lets a short or long frame act. That shows on port_out, port_oe or flag at the end of the same frame, or in the next readback. A wrong match decision shows as ser_oe rising when it should not, or staying low, at slot 6 of the faulty frame. A bad reply index or data source corrupts the byte in slots 9..16 of that frame. A write that reaches the port directly shows on port_out before any drive command is sent.

// File: rtl/ioexp_slave.sv
module ioexp_slave #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              ser_clk,
  input  logic              ser_in,
  input  logic              echo_mode,
  input  logic [3:0]        strap,
  input  logic [PORT_W-1:0] port_in,
  output logic              ser_out,
  output logic              ser_oe,
  output logic [PORT_W-1:0] port_out,
  output logic [PORT_W-1:0] port_oe,
  output logic              flag
);
  localparam int CW = 5;
  localparam logic [CW-1:0] FRAME_LEN = CW'(16);
  localparam logic [CW-1:0] ADDR_LAST = CW'(4);
  localparam logic [CW-1:0] CMD_LAST  = CW'(7);
  localparam logic [CW-1:0] DATA_FIRST = CW'(8);
  localparam logic [2:0] OP_WRITE = 3'b001, OP_DRIVE = 3'b010,
                         OP_RDREG = 3'b100, OP_SET = 3'b101, OP_CLR = 3'b110;

  logic [2:0] ck_p, en_p;
  logic [3:0] di_p;
  logic       active, matched, sdo_q, sdo_oe_q, flag_q;
  logic [CW-1:0] cnt;
  logic [PORT_W+2:0] rx;
  logic [2:0] cmd_q;
  logic [PORT_W-1:0] snap, oreg, pout, pen;

  wire ck_rise = ck_p[1] & ~ck_p[2];
  wire ck_fall = ~ck_p[1] & ck_p[2];
  wire en_fall = ~en_p[1] & en_p[2];
  wire en_rise = en_p[1] & ~en_p[2];
  wire bit_in  = (di_p[1] & di_p[2]) | (di_p[1] & di_p[3]) | (di_p[2] & di_p[3]);
  wire exec    = en_rise & active & matched & (cnt == FRAME_LEN);
  wire [2:0] op = rx[PORT_W+2:PORT_W];

  wire addr_hit = echo_mode ? ({rx[1:0], bit_in} == strap[2:0])
                            : ({rx[2:0], bit_in} == strap);
  wire [PORT_W-1:0] dsel = (cmd_q == OP_RDREG) ? oreg : snap;
  wire [2:0] ridx = ~cnt[2:0];
  wire reply_bit = (cnt >= DATA_FIRST) ? dsel[ridx] :
                   echo_mode ? rx[0] : (cnt == CMD_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_p <= '0;
      en_p <= '1;
      di_p <= '0;
    end else begin
      ck_p <= {ck_p[1:0], ser_clk};
      en_p <= {en_p[1:0], sel_n};
      di_p <= {di_p[2:0], ser_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      matched  <= 1'b0;
      cnt      <= '0;
      rx       <= '0;
      cmd_q    <= '0;
      snap     <= '0;
      sdo_q    <= 1'b0;
      sdo_oe_q <= 1'b0;
    end else if (en_fall) begin
      active   <= 1'b1;
      matched  <= 1'b0;
      cnt      <= '0;
      snap     <= port_in;
      sdo_oe_q <= 1'b0;
    end else if (en_rise) begin
      active   <= 1'b0;
      matched  <= 1'b0;
      cnt      <= '0;
      sdo_oe_q <= 1'b0;
    end else if (active && ck_rise) begin
      rx <= {rx[PORT_W+1:0], bit_in};
      if (cnt != '1) cnt <= cnt + 1'b1;
      if (cnt == ADDR_LAST) matched <= addr_hit;
      if (cnt == CMD_LAST) cmd_q <= {rx[1:0], bit_in};
    end else if (active && ck_fall && matched && cnt < FRAME_LEN) begin
      sdo_oe_q <= 1'b1;
      sdo_q    <= reply_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oreg   <= '0;
      pout   <= '0;
      pen    <= '0;
      flag_q <= 1'b0;
    end else if (exec) begin
      case (op)
        OP_WRITE: oreg <= rx[PORT_W-1:0];
        OP_DRIVE: begin
          pout <= oreg;
          pen  <= '1;
        end
        OP_SET:   flag_q <= 1'b1;
        OP_CLR:   flag_q <= 1'b0;
        default:  ;
      endcase
    end
  end

  assign ser_out  = sdo_q;
  assign ser_oe   = sdo_oe_q;
  assign port_out = pout;
  assign port_oe  = pen;
  assign flag     = flag_q;

  // R5
  oe_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe_q |-> matched);
  // R6
  oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sdo_oe_q);
  // R2
  reg_write_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oreg) |-> $past(exec));
  // R3
  port_drive_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pen) |-> $past(exec));
  // R7
  count_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> cnt == '0);
  // R11
  flag_set_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(exec));
endmodule

// File: tb/ioexp_slave_test.sv
module ioexp_slave_test;
  logic clk = 1'b0, rst_n = 1'b0, sel_n = 1'b1, ser_clk = 1'b0, ser_in = 1'b0;
  logic echo_mode = 1'b0;
  logic [3:0] strap = 4'b1010;
  logic [7:0] port_in = 8'h00;
  logic ser_out, ser_oe, flag;
  logic [7:0] port_out, port_oe;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ioexp_slave uut (.clk, .rst_n, .sel_n, .ser_clk, .ser_in, .echo_mode, .strap,
                   .port_in, .ser_out, .ser_oe, .port_out, .port_oe, .flag);

  typedef struct packed {
    logic echo; logic [15:0] word; logic [4:0] nclk; logic [7:0] pin;
    logic [15:0] rep; logic [15:0] oe; logic [7:0] pout; logic [7:0] pen;
    logic flg; logic [3:0] tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h515A, 5'd16, 8'h3C, 16'h013C, 16'h07FF, 8'h00, 8'h00, 1'b0, 4'd2},
    '{1'b0, 16'h5400, 5'd16, 8'hC3, 16'h015A, 16'h07FF, 8'h00, 8'h00, 1'b0, 4'd4},
    '{1'b0, 16'h52FF, 5'd16, 8'h81, 16'h0181, 16'h07FF, 8'h5A, 8'hFF, 1'b0, 4'd3},
    '{1'b0, 16'h5300, 5'd16, 8'h96, 16'h0196, 16'h07FF, 8'h5A, 8'hFF, 1'b0, 4'd4},
    '{1'b0, 16'h59AA, 5'd16, 8'h00, 16'h0000, 16'h0000, 8'h5A, 8'hFF, 1'b0, 4'd5},
    '{1'b0, 16'h5177, 5'd15, 8'hFF, 16'h01FE, 16'h07FE, 8'h5A, 8'hFF, 1'b0, 4'd7},
    '{1'b0, 16'h5177, 5'd17, 8'h0F, 16'h010F, 16'h07FF, 8'h5A, 8'hFF, 1'b0, 4'd7},
    '{1'b0, 16'h5400, 5'd16, 8'h00, 16'h015A, 16'h07FF, 8'h5A, 8'hFF, 1'b0, 4'd7},
    '{1'b0, 16'h5500, 5'd16, 8'h00, 16'h0100, 16'h07FF, 8'h5A, 8'hFF, 1'b1, 4'd11},
    '{1'b1, 16'h1400, 5'd16, 8'h00, 16'h025A, 16'h07FF, 8'h5A, 8'hFF, 1'b1, 4'd9},
    '{1'b1, 16'h1600, 5'd16, 8'h44, 16'h0344, 16'h07FF, 8'h5A, 8'hFF, 1'b0, 4'd11},
    '{1'b1, 16'hD133, 5'd16, 8'h00, 16'h0000, 16'h07FF, 8'h5A, 8'hFF, 1'b0, 4'd9},
    '{1'b1, 16'h1200, 5'd16, 8'h00, 16'h0100, 16'h07FF, 8'h33, 8'hFF, 1'b0, 4'd3},
    '{1'b1, 16'h1955, 5'd16, 8'h00, 16'h0000, 16'h0000, 8'h33, 8'hFF, 1'b0, 4'd5}
  };

  function automatic string rq(input int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] w, input int nclk, input logic [15:0] gmask,
                       output logic [15:0] rep, output logic [15:0] oe);
    rep = '0;
    oe = '0;
    @(negedge clk) sel_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < nclk; k++) begin
      ser_in = (k < 16) ? w[15-k] : 1'b0;
      repeat (4) @(negedge clk);
      if (k < 16) begin
        rep[15-k] = ser_out;
        oe[15-k]  = ser_oe;
      end
      ser_clk = 1'b1;
      if (k < 16 && gmask[15-k]) begin
        ser_in = ~ser_in;
        @(negedge clk) ser_in = ~ser_in;
        repeat (7) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
      ser_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
    sel_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] rep, oe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1", "ser_oe", {15'd0, ser_oe}, 16'h0);
    check("R1", "port_oe", {8'd0, port_oe}, 16'h0);
    check("R1", "port_out", {8'd0, port_out}, 16'h0);
    check("R1", "flag", {15'd0, flag}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      echo_mode = VEC[i].echo;
      port_in = VEC[i].pin;
      frame(VEC[i].word, int'(VEC[i].nclk), 16'h0, rep, oe);
      check(rq(int'(VEC[i].tag)), "reply bits (R8 ack, R4 data)", rep & VEC[i].oe, VEC[i].rep);
      check("R6", "ser_oe per slot", oe, VEC[i].oe);
      check("R6", "ser_oe after frame", {15'd0, ser_oe}, 16'h0);
      check(rq(int'(VEC[i].tag)), "port_out", {8'd0, port_out}, {8'd0, VEC[i].pout});
      check(rq(int'(VEC[i].tag)), "port_oe", {8'd0, port_oe}, {8'd0, VEC[i].pen});
      check(rq(int'(VEC[i].tag)), "flag", {15'd0, flag}, {15'd0, VEC[i].flg});
    end

    // R10 glitched write then readback
    echo_mode = 1'b0;
    port_in = 8'h00;
    frame(16'h51A5, 16, 16'h00FF, rep, oe);
    check("R10", "port_out after glitched write", {8'd0, port_out}, 16'h0033);
    frame(16'h5400, 16, 16'h0000, rep, oe);
    check("R10", "readback after glitched write", rep, 16'h01A5);
    // R8 normal acknowledge and fill slots
    check("R8", "slots 6..8", {13'd0, rep[10:8]}, 16'h0001);
    // R3 drive the glitch-free value
    frame(16'h5200, 16, 16'h0000, rep, oe);
    check("R3", "port_out after drive", {8'd0, port_out}, 16'h00A5);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule